// File: doc/BRIEF.md
# Modified Second-Order Digital Phase Locked Loop Core

This block is the digital heart of a zero-crossing, nonuniform-sampling phase locked loop. It makes its own sampling instants as single-cycle `tick_o` pulses. About one cycle after each pulse, an external sampler returns a signed quantized sample of the input waveform. The block feeds that sample through a second-order loop filter, which has an accumulator path and a proportional path. The filter output sets the length of the next sampling interval: that length is the nominal period minus the filter output, counted in clock cycles.

Two additions widen the frequency range the loop can acquire. First, the filter input is the raw sample plus a signed gain times the change from the previous sample. Second, the accumulator can be preloaded from outside with a starting value. A positive preload suits inputs above the nominal frequency and a negative preload suits inputs below it. With the difference gain at zero and no preload, the block is an ordinary second-order loop. Once the loop locks, the samples settle near zero and the accumulator alone holds the period correction.

All gains are signed fixed point with `GF` fractional bits. Products are rounded by adding one half and taking the floor. The accumulator saturates instead of wrapping.

Top module: `dpll_core`

## Requirements
- R1: While `rst` is high, `tick_o` is 0 and `y_dbg_o` is 0. Reset also clears the accumulator and the previous-sample register, and loads the period from `t0_i`. The first `tick_o` comes exactly `t0_i` cycles after the last clock edge at which `rst` is high.
- R2: For each valid sample s, the filter input is x = s + floor((P·(s − s_prev) + 2^(GF−1)) / 2^GF). P is `pgain_i` in two's complement with GF = 4 fractional bits, and s_prev is the previous valid sample (0 after reset).
- R3: At the clock edge that samples `smp_vld_i` high, `y_dbg_o` becomes y = floor(((G1+G2)·x + G2·SUM + 2^(GF−1)) / 2^GF). G1 and G2 have GF fractional bits, and SUM is the accumulator before this sample is added. When no valid sample arrives, `y_dbg_o` holds its value.
- R4: After each valid sample the accumulator becomes SUM + x, saturated to the signed range of AW bits (default 20, so at most 524287) instead of wrapping.
- R5: With `pgain_i` = 0, x equals the raw sample, so the loop behaves as the conventional second-order loop.
- R6: When `acc_load_i` is high, the accumulator takes `acc_init_i` at that edge. This wins over an accumulate step in the same cycle. A filter output computed in that same cycle still uses the previous accumulator value.
- R7: The interval from a sampling pulse to the next pulse equals `t0_i` − y, where y is computed from the sample taken at that first pulse. The sample is delivered with a one-cycle valid that is high in the cycle after the pulse.
- R8: The computed period is clamped to at least MIN_PERIOD (default 4) and at most 2^PW − 1.
- R9: `tick_o` is high for exactly one cycle per sampling instant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | SW | Signed quantized sample |
| smp_vld_i | input | 1 | One-cycle strobe marking a sample |
| g1_i | input | GW | Proportional gain G1, signed, GF fractional bits |
| g2_i | input | GW | Integral gain G2, signed, GF fractional bits |
| pgain_i | input | GW | Difference gain P, signed, GF fractional bits |
| t0_i | input | PW | Nominal period in clock cycles |
| acc_init_i | input | AW | Signed accumulator preload value |
| acc_load_i | input | 1 | Preload strobe |
| tick_o | output | 1 | Sampling pulse |
| y_dbg_o | output | YW | Registered filter output, signed |

## Verification
Some properties are checked on every cycle. The stored period never falls below its minimum, a pulse never lasts two cycles, and a preload always lands in the accumulator. The filter output stays constant when no sample arrives, the accumulator never drops on a non-negative step, and with zero difference gain the filter input equals the raw sample. Other behaviour shows only in the bench scenarios. This covers the exact rounded filter values and the pulse-to-pulse interval that follows each sample. It also covers the clamp on an over-large correction, the saturation that follows a near-full preload, and same-cycle preload priority, which is observed through the filter output of the next sample.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  // round-half-up then arithmetic shift by f fractional bits
  function automatic logic signed [63:0] rnd_shr(input logic signed [63:0] v, input int f);
    return (v + (64'sd1 <<< (f - 1))) >>> f;
  endfunction

  // saturate v into the signed range of w bits
  function automatic logic signed [63:0] sat_w(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/dpll_prefilter.sv
module dpll_prefilter
  import dpll_pkg::*;
#(
  parameter int SW = 8,
  parameter int GW = 8,
  parameter int GF = 4,
  parameter int XW = SW + GW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [SW-1:0] s_i,
  input  logic                 vld_i,
  input  logic signed [GW-1:0] p_i,
  output logic signed [XW-1:0] x_o
);
  logic signed [SW-1:0] prev_q;
  logic signed [63:0]   diff, prod;

  always_comb begin
    diff = 64'(s_i) - 64'(prev_q);
    prod = 64'(p_i) * diff;
    x_o  = XW'(64'(s_i) + rnd_shr(prod, GF));
  end

  always_ff @(posedge clk) begin
    if (rst)        prev_q <= '0;
    else if (vld_i) prev_q <= s_i;
  end

  // R5
  pzero_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (p_i == '0) |-> (x_o == XW'(s_i)));
endmodule

// File: rtl/dpll_loopfilter.sv
module dpll_loopfilter
  import dpll_pkg::*;
#(
  parameter int XW = 18,
  parameter int GW = 8,
  parameter int GF = 4,
  parameter int AW = 20,
  parameter int YW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [XW-1:0] x_i,
  input  logic                 vld_i,
  input  logic signed [GW-1:0] g1_i,
  input  logic signed [GW-1:0] g2_i,
  input  logic signed [AW-1:0] init_i,
  input  logic                 load_i,
  output logic signed [YW-1:0] y_nxt_o,
  output logic signed [YW-1:0] y_q
);
  logic signed [AW-1:0] sum_q;
  logic signed [63:0]   gsum, yraw, snext;

  always_comb begin
    gsum    = 64'(g1_i) + 64'(g2_i);
    yraw    = gsum * 64'(x_i) + 64'(g2_i) * 64'(sum_q);
    y_nxt_o = YW'(sat_w(rnd_shr(yraw, GF), YW));
    snext   = 64'(sum_q) + 64'(x_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      y_q   <= '0;
    end else begin
      if (vld_i) y_q <= y_nxt_o;
      if (load_i)     sum_q <= init_i;
      else if (vld_i) sum_q <= AW'(sat_w(snext, AW));
    end
  end

  // R6
  preload_win_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (sum_q == $past(init_i)));
  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !load_i && (x_i >= 0) && (sum_q >= 0)) |=> (sum_q >= $past(sum_q)));
  // R3
  y_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(y_q));
endmodule

// File: rtl/dpll_osc.sv
module dpll_osc #(
  parameter int PW    = 16,
  parameter int YW    = 24,
  parameter int MINP  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        t0_i,
  input  logic signed [YW-1:0] y_nxt_i,
  input  logic                 upd_i,
  output logic                 tick_o
);
  localparam logic signed [63:0] MIN64 = 64'(MINP);
  localparam logic signed [63:0] MAX64 = (64'sd1 <<< PW) - 64'sd1;

  logic [PW-1:0]      per_q, cnt_q, per_nxt;
  logic signed [63:0] pw;

  always_comb begin
    pw = $signed(64'(t0_i)) - 64'(y_nxt_i);
    if (pw < MIN64)      per_nxt = PW'(MINP);
    else if (pw > MAX64) per_nxt = '1;
    else                 per_nxt = PW'(pw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= t0_i;
      cnt_q  <= PW'(1);
      tick_o <= 1'b0;
    end else begin
      if (cnt_q >= per_q) begin
        tick_o <= 1'b1;
        cnt_q  <= PW'(1);
      end else begin
        tick_o <= 1'b0;
        cnt_q  <= cnt_q + PW'(1);
      end
      if (upd_i) per_q <= per_nxt;
    end
  end

  // R8
  per_min_chk: assert property (@(posedge clk) disable iff (rst)
    $past(upd_i) |-> (per_q >= PW'(MINP)));
  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int SW   = 8,
  parameter int GW   = 8,
  parameter int GF   = 4,
  parameter int AW   = 20,
  parameter int YW   = 24,
  parameter int PW   = 16,
  parameter int MIN_PERIOD = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [SW-1:0] smp_i,
  input  logic                 smp_vld_i,
  input  logic signed [GW-1:0] g1_i,
  input  logic signed [GW-1:0] g2_i,
  input  logic signed [GW-1:0] pgain_i,
  input  logic [PW-1:0]        t0_i,
  input  logic signed [AW-1:0] acc_init_i,
  input  logic                 acc_load_i,
  output logic                 tick_o,
  output logic signed [YW-1:0] y_dbg_o
);
  localparam int XW = SW + GW + 2;

  logic signed [XW-1:0] x_w;
  logic signed [YW-1:0] y_nxt_w;

  dpll_prefilter #(.SW(SW), .GW(GW), .GF(GF), .XW(XW)) u_pre (
    .clk(clk), .rst(rst), .s_i(smp_i), .vld_i(smp_vld_i),
    .p_i(pgain_i), .x_o(x_w)
  );

  dpll_loopfilter #(.XW(XW), .GW(GW), .GF(GF), .AW(AW), .YW(YW)) u_lf (
    .clk(clk), .rst(rst), .x_i(x_w), .vld_i(smp_vld_i),
    .g1_i(g1_i), .g2_i(g2_i), .init_i(acc_init_i), .load_i(acc_load_i),
    .y_nxt_o(y_nxt_w), .y_q(y_dbg_o)
  );

  dpll_osc #(.PW(PW), .YW(YW), .MINP(MIN_PERIOD)) u_osc (
    .clk(clk), .rst(rst), .t0_i(t0_i), .y_nxt_i(y_nxt_w),
    .upd_i(smp_vld_i), .tick_o(tick_o)
  );
endmodule

// File: tb/dpll_core_tb.sv
module dpll_core_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst;
  logic signed [7:0]  smp_i, g1_i, g2_i, pgain_i;
  logic               smp_vld_i, acc_load_i;
  logic [15:0]        t0_i;
  logic signed [19:0] acc_init_i;
  logic               tick_o;
  logic signed [23:0] y_dbg_o;

  dpll_core dut_i (
    .clk(clk), .rst(rst), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .g1_i(g1_i), .g2_i(g2_i), .pgain_i(pgain_i), .t0_i(t0_i),
    .acc_init_i(acc_init_i), .acc_load_i(acc_load_i),
    .tick_o(tick_o), .y_dbg_o(y_dbg_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // G1=1.0 G2=0.5 (GF=4), T0=100; columns: P, sample, expected y, expected period
  localparam int NV = 8;
  localparam int TP   [0:NV-1] = '{-2, -2, -2, 0, 0, 16, 0, 0};
  localparam int TS   [0:NV-1] = '{10, 20, -30, -5, 0, 7, 127, -127};
  localparam int TY   [0:NV-1] = '{14, 33, -22, -5, 0, 21, 197, -120};
  localparam int TPER [0:NV-1] = '{86, 67, 122, 105, 100, 79, 4, 220};

  task automatic chk(input string tg, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  // called at the negedge where tick_o was seen high
  task automatic do_sample(input int p, input int s, input bit pre, input int pv,
                           input bit same, input int sv, input longint ey,
                           input int eper, input string tg);
    int cnt;
    pgain_i = 8'(p);
    if (pre) begin acc_load_i = 1'b1; acc_init_i = 20'(pv); end
    @(negedge clk); cnt = 1;
    chk("R9 pulse width", longint'(tick_o), 0);
    acc_load_i = 1'b0;
    smp_vld_i = 1'b1; smp_i = 8'(s);
    if (same) begin acc_load_i = 1'b1; acc_init_i = 20'(sv); end
    @(negedge clk); cnt = 2;
    smp_vld_i = 1'b0; acc_load_i = 1'b0;
    chk({tg, " R3 y"}, longint'(y_dbg_o), ey);
    while (!tick_o && cnt < 70000) begin
      @(negedge clk); cnt++;
    end
    chk({tg, " R7 R8 period"}, cnt, eper);
  endtask

  initial begin
    int cnt;
    rst = 1'b1; smp_i = '0; smp_vld_i = 1'b0; acc_load_i = 1'b0; acc_init_i = '0;
    g1_i = 8'sd16; g2_i = 8'sd8; pgain_i = '0; t0_i = 16'd100;
    repeat (3) @(negedge clk);
    chk("R1 reset tick", longint'(tick_o), 0);
    chk("R1 reset y", longint'(y_dbg_o), 0);
    rst = 1'b0;
    cnt = 0;
    while (!tick_o && cnt < 70000) begin
      @(negedge clk); cnt++;
    end
    chk("R1 first interval", cnt, 100);

    for (int i = 0; i < NV; i++)
      do_sample(TP[i], TS[i], 0, 0, 0, 0, TY[i], TPER[i], "R2 R5 vec");

    // R6: preload 80, then sample 0 -> y=40, period 60
    do_sample(0, 0, 1, 80, 0, 0, 40, 60, "R6 preload");
    // R6: load 50 with the valid; y uses old SUM 80
    do_sample(0, 0, 0, 0, 1, 50, 40, 60, "R6 same-cycle");
    // R6: SUM now 50 -> y=25
    do_sample(0, 0, 0, 0, 0, 0, 25, 75, "R6 priority");
    // R4: near-full preload then saturate
    do_sample(0, 127, 1, 524280, 0, 0, 262331, 4, "R4 R8 big");
    do_sample(0, 0, 0, 0, 0, 0, 262144, 4, "R4 saturated");
    // R6: negative preload for low input frequency
    do_sample(0, 0, 1, -100, 0, 0, -50, 150, "R6 negative");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule